// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block stands in for the management register set of one Ethernet PHY. It is not a serial pin engine. The host drives a 32-bit management frame together with a one-cycle strobe. The frame holds an operation bit, a 9-bit register address and a 16-bit data field. A read loads the value of the addressed register into the frame register, with the upper half zero. A write updates the writable registers and leaves the written frame in the frame register. Each access, read or write, produces a one-cycle done pulse that a parent event register can latch.

The model holds fixed identity values and applies a write mask to each writable register. Its interrupt-source register clears when read, and its interrupt mask keeps 8 bits. Autonegotiation completes at once and follows the level of the `link_up` input. Each change of `link_up`, and each PHY reset (bus reset or a soft reset through the control register), refreshes the link-dependent status bits and latches link events into the interrupt-source register.

Top module: `phy_mgmt_model`

## Requirements
- R1: After reset, control reads 0x3000, advertisement 0x01E1 and interrupt mask 0. One cycle later the link state is applied. With the link down, status then reads 0x7809 and interrupt source reads 0x0010.
- R2: Frame bit 28 selects write (1) or read (0). Bits 26:18 carry the register address and bits 15:0 the write data. A read places the register value in frame bits 15:0 and zero in bits 31:16.
- R3: Register 2 reads 0x0007, register 3 reads 0xC0D1, register 5 reads 0x0F71 and register 6 reads 0x0001.
- R4: A write to register 0 with bit 15 clear stores the data ANDed with 0x7980. If data bit 12 is set, status bit 5 (0x0020) is also set.
- R5: A write to register 0 with bit 15 set returns control, status, advertisement, mask and interrupt source to their reset values, and then applies the link state.
- R6: A write to register 4 stores (data AND 0x2D7F) OR 0x0080.
- R7: A read of register 29 returns the interrupt source and then clears it.
- R8: A write to register 30 stores data bits 7:0 as the interrupt mask, and register 30 reads it back.
- R9: On a link rise, status bits 0x0024 are set and interrupt bits 7 and 6 are set. On a link fall, status bits 0x0024 are cleared and interrupt bit 4 is set.
- R10: Addresses above 31 and registers 17, 18, 27 and 31 read as zero. Writes to any register other than 0, 4 and 30 have no effect, and this includes addresses above 31 that alias low registers.
- R11: `mgmt_done` is high for exactly the one cycle after each accepted access and is low at every other time.
- R12: After a write, the frame register holds the written frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mgmt_wr | input | 1 | One-cycle strobe: the host issues a management frame |
| mgmt_wdata | input | 32 | Management frame written by the host |
| link_up | input | 1 | Current link level, synchronous to clk |
| mgmt_frame | output | 32 | Frame register: read result or echoed write frame |
| mgmt_done | output | 1 | One-cycle pulse after every access |

## Verification
A frame sampled at a clock edge puts its result in `mgmt_frame` and raises `mgmt_done` at that same edge, so both can be seen at the following falling edge. A link change, or a pending link refresh after reset, takes effect at the next edge. A read issued after that edge therefore sees the refreshed state. The bench runs a behavioural model at every rising edge and compares the frame register and the done flag with it at every falling edge. Each targeted access checks its literal expected value at the falling edge after the strobe is sampled. Link changes are given at least two cycles to settle before any read checks them.

// File: rtl/phy_mgmt_pkg.sv
// Shared constants and types for the PHY management register model.
// Assumes a 32-bit management frame with fixed field positions.
package phy_mgmt_pkg;
    localparam int FRAME_W   = 32;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 9;
    localparam int REG_IDX_W = 5;
    localparam int OP_BIT    = 28;
    localparam int ADDR_LSB  = 18;
    localparam int MASK_W    = 8;

    localparam logic [REG_IDX_W-1:0] RA_CTRL  = 5'd0;
    localparam logic [REG_IDX_W-1:0] RA_STAT  = 5'd1;
    localparam logic [REG_IDX_W-1:0] RA_ID1   = 5'd2;
    localparam logic [REG_IDX_W-1:0] RA_ID2   = 5'd3;
    localparam logic [REG_IDX_W-1:0] RA_ADV   = 5'd4;
    localparam logic [REG_IDX_W-1:0] RA_LPA   = 5'd5;
    localparam logic [REG_IDX_W-1:0] RA_EXP   = 5'd6;
    localparam logic [REG_IDX_W-1:0] RA_ISRC  = 5'd29;
    localparam logic [REG_IDX_W-1:0] RA_IMASK = 5'd30;

    localparam logic [DATA_W-1:0] CTRL_RST   = 16'h3000;
    localparam logic [DATA_W-1:0] STAT_RST   = 16'h7809;
    localparam logic [DATA_W-1:0] ADV_RST    = 16'h01E1;
    localparam logic [DATA_W-1:0] CTRL_WMASK = 16'h7980;
    localparam logic [DATA_W-1:0] ADV_WMASK  = 16'h2D7F;
    localparam logic [DATA_W-1:0] ADV_FORCE  = 16'h0080;
    localparam logic [DATA_W-1:0] AN_DONE    = 16'h0020;
    localparam logic [DATA_W-1:0] LINK_BITS  = 16'h0024;
    localparam logic [DATA_W-1:0] VAL_ID1    = 16'h0007;
    localparam logic [DATA_W-1:0] VAL_ID2    = 16'hC0D1;
    localparam logic [DATA_W-1:0] VAL_LPA    = 16'h0F71;
    localparam logic [DATA_W-1:0] VAL_EXP    = 16'h0001;
    localparam int CTRL_SOFT_RST = 15;
    localparam int CTRL_AN_EN    = 12;

    localparam logic [MASK_W-1:0] EV_UP   = 8'hC0;
    localparam logic [MASK_W-1:0] EV_DOWN = 8'h10;

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } mgmt_acc_t;
endpackage

// File: rtl/phy_reg_file.sv
// Writable and link-dependent PHY registers.
// Assumes link_up is synchronous to clk. Writes outside 0/4/30 are dropped.
module phy_reg_file
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mgmt_acc_t         acc,
    input  logic              link_up,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] adv_q,
    output logic [MASK_W-1:0] imask_q,
    output logic [MASK_W-1:0] isrc_q
);
    logic [DATA_W-1:0] ctrl_n, stat_n, adv_n;
    logic [MASK_W-1:0] imask_n, isrc_n;
    logic              pend_q, pend_n, link_q, apply, in_range;
    logic [REG_IDX_W-1:0] ra;

    assign in_range = (acc.addr[ADDR_W-1:REG_IDX_W] == '0);
    assign ra       = acc.addr[REG_IDX_W-1:0];
    assign apply    = pend_q || (link_up != link_q);

    // Next state: access effect first, then link refresh on top.
    always_comb begin
        ctrl_n  = ctrl_q;
        stat_n  = stat_q;
        adv_n   = adv_q;
        imask_n = imask_q;
        isrc_n  = isrc_q;
        pend_n  = 1'b0;
        if (acc.valid && acc.wr && in_range) begin
            case (ra)
                RA_CTRL: begin
                    if (acc.data[CTRL_SOFT_RST]) begin
                        ctrl_n  = CTRL_RST;
                        stat_n  = STAT_RST;
                        adv_n   = ADV_RST;
                        imask_n = '0;
                        isrc_n  = '0;
                        pend_n  = 1'b1;
                    end else begin
                        ctrl_n = acc.data & CTRL_WMASK;
                        if (acc.data[CTRL_AN_EN]) stat_n = stat_n | AN_DONE;
                    end
                end
                RA_ADV:   adv_n   = (acc.data & ADV_WMASK) | ADV_FORCE;
                RA_IMASK: imask_n = acc.data[MASK_W-1:0];
                default:  ;
            endcase
        end
        if (acc.valid && !acc.wr && in_range && ra == RA_ISRC) isrc_n = '0;
        if (apply) begin
            if (link_up) begin
                stat_n = stat_n | LINK_BITS;
                isrc_n = isrc_n | EV_UP;
            end else begin
                stat_n = stat_n & ~LINK_BITS;
                isrc_n = isrc_n | EV_DOWN;
            end
        end
    end

    // Register update; reset arms a link refresh for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            stat_q  <= STAT_RST;
            adv_q   <= ADV_RST;
            imask_q <= '0;
            isrc_q  <= '0;
            pend_q  <= 1'b1;
            link_q  <= link_up;
        end else begin
            ctrl_q  <= ctrl_n;
            stat_q  <= stat_n;
            adv_q   <= adv_n;
            imask_q <= imask_n;
            isrc_q  <= isrc_n;
            pend_q  <= pend_n;
            link_q  <= link_up;
        end
    end

    // R4
    ctrl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_WMASK) == '0);
    // R6
    adv_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_q[7] == 1'b1);
    // R7
    isrc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.valid && !acc.wr && in_range && ra == RA_ISRC && !apply) |=> isrc_q == '0);
    // R9
    link_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && link_up) |=> (stat_q[5] && stat_q[2] && isrc_q[7] && isrc_q[6]));
    // R9
    link_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !link_up) |=> (!stat_q[5] && !stat_q[2] && isrc_q[4]));
endmodule

// File: rtl/phy_read_mux.sv
// Read-data selection for the management frame.
// Assumes unimplemented and out-of-range addresses read as zero.
module phy_read_mux
    import phy_mgmt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [DATA_W-1:0] stat_q,
    input  logic [DATA_W-1:0] adv_q,
    input  logic [MASK_W-1:0] imask_q,
    input  logic [MASK_W-1:0] isrc_q,
    output logic [DATA_W-1:0] rd_data
);
    // Address decode to register value.
    always_comb begin
        rd_data = '0;
        if (addr[ADDR_W-1:REG_IDX_W] == '0) begin
            case (addr[REG_IDX_W-1:0])
                RA_CTRL:  rd_data = ctrl_q;
                RA_STAT:  rd_data = stat_q;
                RA_ID1:   rd_data = VAL_ID1;
                RA_ID2:   rd_data = VAL_ID2;
                RA_ADV:   rd_data = adv_q;
                RA_LPA:   rd_data = VAL_LPA;
                RA_EXP:   rd_data = VAL_EXP;
                RA_ISRC:  rd_data = {{(DATA_W-MASK_W){1'b0}}, isrc_q};
                RA_IMASK: rd_data = {{(DATA_W-MASK_W){1'b0}}, imask_q};
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/phy_mgmt_model.sv
// Top of the PHY management register model: frame decode, frame register
// and done pulse. Assumes the host strobes mgmt_wr for one cycle per frame.
module phy_mgmt_model
    import phy_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mgmt_wr,
    input  logic [FRAME_W-1:0] mgmt_wdata,
    input  logic               link_up,
    output logic [FRAME_W-1:0] mgmt_frame,
    output logic               mgmt_done
);
    mgmt_acc_t         acc;
    logic [DATA_W-1:0] ctrl_q, stat_q, adv_q, rd_data;
    logic [MASK_W-1:0] imask_q, isrc_q;
    logic [FRAME_W-1:0] frame_q;
    logic               done_q;

    // Split the incoming frame into its fields.
    always_comb begin
        acc.valid = mgmt_wr;
        acc.wr    = mgmt_wdata[OP_BIT];
        acc.addr  = mgmt_wdata[ADDR_LSB+ADDR_W-1:ADDR_LSB];
        acc.data  = mgmt_wdata[DATA_W-1:0];
    end

    phy_reg_file u_regs (
        .clk(clk), .rst_n(rst_n), .acc(acc), .link_up(link_up),
        .ctrl_q(ctrl_q), .stat_q(stat_q), .adv_q(adv_q),
        .imask_q(imask_q), .isrc_q(isrc_q)
    );

    phy_read_mux u_rmux (
        .addr(acc.addr), .ctrl_q(ctrl_q), .stat_q(stat_q), .adv_q(adv_q),
        .imask_q(imask_q), .isrc_q(isrc_q), .rd_data(rd_data)
    );

    // Frame register captures read data or echoes a write; done follows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= mgmt_wr;
            if (mgmt_wr) begin
                if (acc.wr) frame_q <= mgmt_wdata;
                else        frame_q <= {{(FRAME_W-DATA_W){1'b0}}, rd_data};
            end
        end
    end

    assign mgmt_frame = frame_q;
    assign mgmt_done  = done_q;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_wr |=> mgmt_done);
    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_wr |=> !mgmt_done);
    // R2
    rd_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && !mgmt_wdata[OP_BIT]) |=> mgmt_frame[FRAME_W-1:DATA_W] == '0);
    // R12
    wr_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && mgmt_wdata[OP_BIT]) |=> mgmt_frame == $past(mgmt_wdata));
endmodule

// File: tb/phy_mgmt_model_bench.sv
`timescale 1ns/1ps
module phy_mgmt_model_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_wr = 1'b0;
    logic [31:0] mgmt_wdata = '0;
    logic        link_up = 1'b0;
    logic [31:0] mgmt_frame;
    logic        mgmt_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    phy_mgmt_model u_phy_mgmt_model (
        .clk(clk), .rst_n(rst_n), .mgmt_wr(mgmt_wr), .mgmt_wdata(mgmt_wdata),
        .link_up(link_up), .mgmt_frame(mgmt_frame), .mgmt_done(mgmt_done)
    );

    // Behavioural reference state.
    int m_ctrl, m_stat, m_adv, m_mask, m_isrc, m_frame;
    bit m_pend, m_lprev, m_done;

    function automatic int model_read(int a);
        if (a > 31) return 0;
        case (a)
            0: return m_ctrl;
            1: return m_stat;
            2: return 'h0007;
            3: return 'hC0D1;
            4: return m_adv;
            5: return 'h0F71;
            6: return 1;
            29: return m_isrc;
            30: return m_mask;
            default: return 0;
        endcase
    endfunction

    task automatic model_phy_reset();
        m_ctrl = 'h3000; m_stat = 'h7809; m_adv = 'h01E1;
        m_mask = 0; m_isrc = 0; m_pend = 1'b1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_phy_reset();
            m_lprev = link_up; m_frame = 0; m_done = 1'b0;
        end else begin
            bit do_link;
            int a, d;
            do_link = m_pend || (link_up != m_lprev);
            m_pend = 1'b0;
            a = int'(mgmt_wdata[26:18]);
            d = int'(mgmt_wdata[15:0]);
            if (mgmt_wr) begin
                if (mgmt_wdata[28]) begin
                    m_frame = int'(mgmt_wdata);
                    if (a == 0) begin
                        if (d[15]) model_phy_reset();
                        else begin
                            m_ctrl = d & 'h7980;
                            if (d[12]) m_stat = m_stat | 'h20;
                        end
                    end else if (a == 4) m_adv = (d & 'h2D7F) | 'h80;
                    else if (a == 30) m_mask = d & 'hFF;
                end else begin
                    m_frame = model_read(a);
                    if (a == 29) m_isrc = 0;
                end
            end
            if (do_link) begin
                if (link_up) begin m_stat = m_stat | 'h24; m_isrc = m_isrc | 'hC0; end
                else begin m_stat = m_stat & ~'h24; m_isrc = m_isrc | 'h10; end
            end
            m_lprev = link_up;
            m_done = mgmt_wr;
        end
    end

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison with the reference model (R2, R11, R12).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2/R12 model frame", mgmt_frame, 32'(m_frame));
            check("R11 model done", mgmt_done, m_done);
        end
    end

    function automatic logic [31:0] frm(bit wr, int a, int d);
        return {3'b000, wr, 1'b0, 9'(a), 2'b00, 16'(d)};
    endfunction

    task automatic access(logic [31:0] f);
        @(negedge clk);
        mgmt_wr = 1'b1; mgmt_wdata = f;
        @(negedge clk);
        mgmt_wr = 1'b0; mgmt_wdata = '0;
    endtask

    task automatic rd(string tag, int a, int exp);
        access(frm(1'b0, a, 0));
        check(tag, mgmt_frame, 32'(exp));
    endtask

    task automatic wr(string tag, int a, int d);
        access(frm(1'b1, a, d));
        check(tag, mgmt_frame, frm(1'b1, a, d));
    endtask

    task automatic settle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            finish_run();
        end
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        check("R1 reset frame", mgmt_frame, 0);
        check("R11 reset done", mgmt_done, 0);
        settle(2);
        rd("R1 ctrl", 0, 'h3000);
        check("R11 done after access", mgmt_done, 1);
        settle(1);
        check("R11 done single cycle", mgmt_done, 0);
        rd("R1 status", 1, 'h7809);
        rd("R1 adv", 4, 'h01E1);
        rd("R1 mask", 30, 0);
        rd("R1 isrc link down", 29, 'h0010);
        rd("R7 isrc cleared", 29, 0);
        rd("R3 id1", 2, 'h0007);
        rd("R3 id2", 3, 'hC0D1);
        rd("R3 lpa", 5, 'h0F71);
        rd("R3 exp", 6, 1);
        // R2: noise in unused frame bits, upper half of result zero
        access(32'hE000_0000 | frm(1'b0, 2, 'hFFFF) | 32'h0003_0000);
        check("R2 read upper zero", mgmt_frame, 32'h0000_0007);
        // R9 link rise and fall
        link_up = 1'b1; settle(2);
        rd("R9 status up", 1, 'h782D);
        rd("R9 isrc up", 29, 'h00C0);
        link_up = 1'b0; settle(2);
        rd("R9 status down", 1, 'h7809);
        rd("R9 isrc down", 29, 'h0010);
        // R4 control masking and autoneg bit
        wr("R12 ctrl echo", 0, 'h7FFF);
        rd("R4 ctrl masked", 0, 'h7980);
        rd("R4 status an bit", 1, 'h7829);
        wr("R12 ctrl echo", 0, 'h0100);
        rd("R4 ctrl no an", 0, 'h0100);
        rd("R4 status kept", 1, 'h7829);
        // R6 advertisement
        wr("R12 adv echo", 4, 'hFFFF);
        rd("R6 adv all ones", 4, 'h2DFF);
        wr("R12 adv echo", 4, 0);
        rd("R6 adv forced bit", 4, 'h0080);
        // R8 mask
        wr("R12 mask echo", 30, 'hABCD);
        rd("R8 mask low byte", 30, 'h00CD);
        // R10 ignored writes and zero reads
        wr("R12 id write echo", 2, 'h1234);
        rd("R10 id unchanged", 2, 'h0007);
        wr("R12 alias write echo", 32, 'h8000);
        rd("R10 alias no reset", 4, 'h0080);
        wr("R12 alias write echo", 36, 'hFFFF);
        rd("R10 alias adv unchanged", 4, 'h0080);
        rd("R10 reg17", 17, 0);
        rd("R10 reg18", 18, 0);
        rd("R10 reg27", 27, 0);
        rd("R10 reg31", 31, 0);
        rd("R10 addr 256", 256, 0);
        rd("R10 addr 33", 33, 0);
        // R5 soft reset through control, link up at that time
        link_up = 1'b1; settle(2);
        rd("R9 isrc up again", 29, 'h00C0);
        wr("R12 reset echo", 0, 'h8000);
        settle(1);
        rd("R5 ctrl", 0, 'h3000);
        rd("R5 adv", 4, 'h01E1);
        rd("R5 mask", 30, 0);
        rd("R5 status with link", 1, 'h782D);
        rd("R5 isrc with link", 29, 'h00C0);
        // R1 bus reset with link down
        link_up = 1'b0;
        @(negedge clk); rst_n = 1'b0; settle(2); rst_n = 1'b1; settle(2);
        rd("R1 status after reset", 1, 'h7809);
        rd("R1 isrc after reset", 29, 'h0010);
        settle(2);
        finish_run();
    end
endmodule